// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Peripheral

This block is an arithmetic peripheral on a CPU register port. Software loads two operand words and a two-word accumulator, picks a combining mode and a number interpretation in a control byte, and starts a calculation. The block multiplies the two operands and combines the 64-bit product with the 64-bit accumulator. It can add the product, subtract it, or subtract the accumulator from the product. The result goes back into the accumulator, and a sticky flag records whether any result left the 64-bit range.

A calculation can start in two ways. The first is automatic: a write to the lowest byte lane of one chosen register starts it, so the last operand store launches the work. The second is a soft start bit in the control byte. The register port is plain, with no valid/ready handshake. Every write and every read completes in the cycle it is presented, so there is no back-pressure. Reads are combinational on the word address. A calculation finishing in the same cycle as a bus write to the accumulator takes priority over that write.

Top module: `mac_periph`

## Requirements
- R1: After reset every register is zero: both operands, both accumulator words and the control byte read back 0.
- R2: Word addresses are 0 for operand A, 1 for operand B, 2 for accumulator bits 31:0, 3 for accumulator bits 63:32 and 4 for the control byte in bits 7:0. A byte-enable bit gates each byte lane of a write. Writes take effect at the next clock edge. Other addresses read 0.
- R3: Mode code 0 yields accumulator + A×B. Code 1 yields accumulator − A×B. Code 2 yields A×B − accumulator. The result is kept modulo 2^64 and is readable from the second cycle after the launching write.
- R4: With control bit 2 clear, the operands and the accumulator are unsigned. With it set, they are two's-complement signed.
- R5: Control bits 5:3 choose the launch source. Value 0 launches on a write to operand A, 1 on a write to operand B, 2 on a write to the accumulator low word and 3 on a write to the accumulator high word. Each of these needs byte-enable bit 0 set; a write that leaves lane 0 disabled launches nothing.
- R6: A control write with bit 6 set starts a calculation only if the trigger value written in bits 5:3 has bit 5 set. Otherwise it is ignored. Bit 6 always reads 0.
- R7: Overflow means the exact result does not fit. In unsigned mode that is a carry out of 64 bits or a borrow below zero. In signed mode it is a result outside the signed 64-bit range. Overflow sets control bit 7.
- R8: Bit 7 is sticky. Only a control write with bit 7 clear and lane 0 enabled clears it. Writing 1 never sets it. A setting overflow in the same cycle wins over a clear.
- R9: With mode code 3, a launch leaves the accumulator and bit 7 unchanged.
- R10: Control bits 5:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |

## Verification
A launching write is captured at clock edge one. The launch is registered there, and the accumulator and the overflow flag change at edge two. The bench drives each write for exactly one cycle starting at a falling edge. Every read first waits for the next falling edge, so it samples after edge two and never on the edge itself. Register and control readbacks need only the single write edge, and they are sampled under the same rule.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MODE_ADD  = 2'd0,
    MODE_SUB  = 2'd1,
    MODE_RSUB = 2'd2,
    MODE_RSV  = 2'd3
  } mac_mode_e;

  localparam int ADDR_OPA   = 0;
  localparam int ADDR_OPB   = 1;
  localparam int ADDR_ACCLO = 2;
  localparam int ADDR_ACCHI = 3;
  localparam int ADDR_CTRL  = 4;

  localparam int CB_OVF   = 7;
  localparam int CB_START = 6;
  localparam int CB_TRIGH = 5;
  localparam int CB_TRIGL = 3;
  localparam int CB_SIGN  = 2;
endpackage

// File: rtl/mac_arith.sv
module mac_arith
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [2*DW-1:0] acc,
  input  logic            sgn,
  input  mac_mode_e       mode,
  output logic [2*DW-1:0] res,
  output logic            ovf
);
  localparam int PW = 2 * DW;
  localparam int XW = PW + 2;

  logic [PW-1:0] a_ext, b_ext, prod;
  logic [XW-1:0] p_x, c_x, sum_x;
  logic [2:0]    top3;

  always_comb begin
    a_ext = {{DW{sgn & opa[DW-1]}}, opa};
    b_ext = {{DW{sgn & opb[DW-1]}}, opb};
    prod  = a_ext * b_ext;
    p_x   = {{2{sgn & prod[PW-1]}}, prod};
    c_x   = {{2{sgn & acc[PW-1]}}, acc};
    case (mode)
      MODE_ADD:  sum_x = c_x + p_x;
      MODE_SUB:  sum_x = c_x - p_x;
      MODE_RSUB: sum_x = p_x - c_x;
      default:   sum_x = c_x;
    endcase
    res  = sum_x[PW-1:0];
    top3 = sum_x[XW-1:PW-1];
    if (mode == MODE_RSV) ovf = 1'b0;
    else if (sgn)         ovf = !((&top3) || (~|top3));
    else                  ovf = |sum_x[XW-1:PW];
  end
endmodule

// File: rtl/mac_launch.sv
module mac_launch
  import mac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int ABITS = 3,
  parameter int NBE   = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [ABITS-1:0] addr,
  input  logic [NBE-1:0]   be,
  input  logic [DW-1:0]    wdata,
  input  logic [2:0]       trig_sel,
  output logic             go
);
  localparam int NSRC = 5;
  logic [NSRC-1:0] hits;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign hits[i] = wr && be[0] && (addr == ABITS'(i)) && (trig_sel == 3'(i));
  end
  assign hits[4] = wr && be[0] && (addr == ABITS'(ADDR_CTRL))
                   && wdata[CB_START] && wdata[CB_TRIGH];

  always_ff @(posedge clk) begin
    if (!rst_n) go <= 1'b0;
    else        go <= |hits;
  end

  assert_single_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hits));
  assert_soft_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ABITS'(ADDR_CTRL) && !wdata[CB_TRIGH]) |=> !go);
endmodule

// File: rtl/mac_periph.sv
module mac_periph
  import mac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int ABITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [ABITS-1:0] bus_addr,
  input  logic [DW/8-1:0]  bus_be,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata
);
  localparam int NBE = DW / 8;
  localparam int PW  = 2 * DW;

  logic [DW-1:0] opa_q, opb_q;
  logic [PW-1:0] acc_q, calc_res;
  logic [2:0]    trig_q;
  logic          sgn_q, ovf_q, go, calc_ovf;
  mac_mode_e     mode_q;
  logic          ctrl_wr, ovf_clear;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                          input logic [DW-1:0] new_v,
                                          input logic [NBE-1:0] en);
    logic [DW-1:0] r;
    r = old_v;
    for (int k = 0; k < NBE; k++)
      if (en[k]) r[8*k +: 8] = new_v[8*k +: 8];
    return r;
  endfunction

  function automatic logic hit(input int a);
    return bus_wr && (bus_addr == ABITS'(a));
  endfunction

  assign ctrl_wr   = hit(ADDR_CTRL) && bus_be[0];
  assign ovf_clear = ctrl_wr && !bus_wdata[CB_OVF];

  mac_arith #(.DW(DW)) u_arith (
    .opa(opa_q), .opb(opb_q), .acc(acc_q), .sgn(sgn_q), .mode(mode_q),
    .res(calc_res), .ovf(calc_ovf)
  );

  mac_launch #(.DW(DW), .ABITS(ABITS), .NBE(NBE)) u_launch (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .be(bus_be),
    .wdata(bus_wdata), .trig_sel(trig_q), .go(go)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      acc_q  <= '0;
      trig_q <= '0;
      sgn_q  <= 1'b0;
      mode_q <= MODE_ADD;
      ovf_q  <= 1'b0;
    end else begin
      if (hit(ADDR_OPA)) opa_q <= merge(opa_q, bus_wdata, bus_be);
      if (hit(ADDR_OPB)) opb_q <= merge(opb_q, bus_wdata, bus_be);
      if (go && mode_q != MODE_RSV) begin
        acc_q <= calc_res;
      end else begin
        if (hit(ADDR_ACCLO)) acc_q[DW-1:0]  <= merge(acc_q[DW-1:0], bus_wdata, bus_be);
        if (hit(ADDR_ACCHI)) acc_q[PW-1:DW] <= merge(acc_q[PW-1:DW], bus_wdata, bus_be);
      end
      if (ctrl_wr) begin
        trig_q <= bus_wdata[CB_TRIGH:CB_TRIGL];
        sgn_q  <= bus_wdata[CB_SIGN];
        mode_q <= mac_mode_e'(bus_wdata[1:0]);
      end
      if (go && calc_ovf) ovf_q <= 1'b1;
      else if (ovf_clear) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      ADDR_OPA:   bus_rdata = opa_q;
      ADDR_OPB:   bus_rdata = opb_q;
      ADDR_ACCLO: bus_rdata = acc_q[DW-1:0];
      ADDR_ACCHI: bus_rdata = acc_q[PW-1:DW];
      ADDR_CTRL:  bus_rdata[7:0] = {ovf_q, 1'b0, trig_q, sgn_q, mode_q};
      default:    bus_rdata = '0;
    endcase
  end

  assert_reserved_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode_q == MODE_RSV && !hit(ADDR_ACCLO) && !hit(ADDR_ACCHI)) |=> $stable(acc_q));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clear) |=> ovf_q);
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && calc_ovf) |=> ovf_q);
  assert_uadd_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode_q == MODE_ADD && !sgn_q && !calc_ovf) |=> (acc_q >= $past(acc_q)));
  assert_start_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ABITS'(ADDR_CTRL)) |-> !bus_rdata[CB_START]);
endmodule

// File: tb/mac_periph_test.sv
`timescale 1ns/1ps
module mac_periph_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mac_periph uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  typedef struct packed {
    logic        sgn;
    logic [1:0]  mode;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] acc;
    logic [63:0] exp;
    logic        ovf;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 32'd3, 32'd5, 64'd10, 64'd25, 1'b0},
    '{1'b0, 2'd1, 32'd2, 32'd3, 64'd10, 64'd4, 1'b0},
    '{1'b0, 2'd2, 32'd4, 32'd5, 64'd7, 64'd13, 1'b0},
    '{1'b0, 2'd1, 32'd1, 32'd1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    '{1'b0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0200_0000_0000_0000,
      64'h01FF_FFFE_0000_0001, 1'b1},
    '{1'b1, 2'd0, 32'hFFFF_FFFD, 32'd5, 64'd10, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0},
    '{1'b1, 2'd1, 32'hFFFF_FFFE, 32'hFFFF_FFFC, 64'd5, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0},
    '{1'b1, 2'd2, 32'd6, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFA, 64'd0, 1'b0},
    '{1'b1, 2'd0, 32'd1, 32'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1},
    '{1'b1, 2'd2, 32'h8000_0000, 32'h8000_0000, 64'hC000_0000_0000_0000,
      64'h8000_0000_0000_0000, 1'b1},
    '{1'b0, 2'd1, 32'd2, 32'd3, 64'd6, 64'd0, 1'b0}
  };

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 3'(a);
    #1 d = bus_rdata;
  endtask

  task automatic rd_acc(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(2, lo);
    rd(3, hi);
    v = {hi, lo};
  endtask

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc);
    wr(0, 4'hF, a);
    wr(1, 4'hF, b);
    wr(2, 4'hF, acc[31:0]);
    wr(3, 4'hF, acc[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk("R1 reset readback", 64'(d), 64'd0);
    end

    // Table walk: R3 R4 R7, soft start with trigger 111
    for (int i = 0; i < NV; i++) begin
      wr(4, 4'h1, {24'd0, 2'b00, 3'b111, VEC[i].sgn, VEC[i].mode});
      load(VEC[i].a, VEC[i].b, VEC[i].acc);
      wr(4, 4'h1, {24'd0, 2'b01, 3'b111, VEC[i].sgn, VEC[i].mode});
      rd_acc(v);
      chk($sformatf("R3/R4 vector %0d result", i), v, VEC[i].exp);
      rd(4, d);
      chk($sformatf("R7 vector %0d overflow", i), 64'(d[7]), 64'(VEC[i].ovf));
    end

    // R2: register readback with byte lanes
    wr(4, 4'h1, 32'h0000_0038);
    wr(0, 4'hF, 32'h1122_3344);
    wr(0, 4'b0100, 32'hAAAA_AAAA);
    rd(0, d);
    chk("R2 byte lane merge", 64'(d), 64'h11AA_3344);
    rd(6, d);
    chk("R2 unmapped reads zero", 64'(d), 64'd0);

    // R5: trigger on operand A low lane
    wr(4, 4'h1, 32'h0000_0000);
    wr(1, 4'hF, 32'd3);
    wr(2, 4'hF, 32'd1);
    wr(3, 4'hF, 32'd0);
    wr(0, 4'hF, 32'd2);
    rd_acc(v);
    chk("R5 trigger on operand A", v, 64'd7);
    wr(0, 4'b1110, 32'd0);
    rd_acc(v);
    chk("R5 lane0 disabled no launch", v, 64'd7);
    // trigger on operand B
    wr(4, 4'h1, 32'h0000_0008);
    wr(1, 4'h1, 32'd3);
    rd_acc(v);
    chk("R5 trigger on operand B", v, 64'd13);
    // trigger on accumulator low word (uses new value)
    wr(4, 4'h1, 32'h0000_0010);
    wr(0, 4'hF, 32'd2);
    wr(1, 4'hF, 32'd2);
    wr(3, 4'hF, 32'd0);
    wr(2, 4'hF, 32'd1);
    rd_acc(v);
    chk("R5 trigger on accumulator low", v, 64'd5);
    // trigger on accumulator high word lane 0
    wr(4, 4'h1, 32'h0000_0018);
    wr(2, 4'hF, 32'd1);
    wr(3, 4'h1, 32'd0);
    rd_acc(v);
    chk("R5 trigger on accumulator high", v, 64'd5);

    // R6: soft start ignored when trigger field not 1xx
    wr(4, 4'h1, 32'h0000_0040);
    rd_acc(v);
    chk("R6 soft start ignored", v, 64'd5);
    rd(4, d);
    chk("R6 start bit reads zero", 64'(d[7:0]), 64'h00);

    // R10 + R9: reserved mode, readback of fields
    wr(4, 4'h1, 32'h0000_003F);
    rd(4, d);
    chk("R10 control readback", 64'(d[7:0]), 64'h3F);
    wr(4, 4'h1, 32'h0000_007F);
    rd_acc(v);
    chk("R9 reserved mode keeps accumulator", v, 64'd5);
    rd(4, d);
    chk("R9 reserved mode flag clear", 64'(d[7:0]), 64'h3F);

    // R8: sticky overflow
    wr(4, 4'h1, 32'h0000_0039);
    load(32'd1, 32'd1, 64'd0);
    wr(4, 4'h1, 32'h0000_0079);
    rd(4, d);
    chk("R8 overflow set", 64'(d[7]), 64'd1);
    load(32'd1, 32'd1, 64'd100);
    wr(4, 4'h1, 32'h0000_00F9);
    rd_acc(v);
    chk("R8 later calc result", v, 64'd99);
    rd(4, d);
    chk("R8 flag stays after clean calc", 64'(d[7]), 64'd1);
    wr(4, 4'h1, 32'h0000_0039);
    rd(4, d);
    chk("R8 write zero clears", 64'(d[7]), 64'd0);
    wr(4, 4'h1, 32'h0000_00B9);
    rd(4, d);
    chk("R8 write one has no effect", 64'(d[7]), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule